// File: doc/BRIEF.md
# Waveform Output FIFO Sequencer

The sequencer takes samples from a host write port and hands them to a DAC, one sample for each single-cycle update tick. It has two paths. In the direct path, a single sample held in a register goes to the DAC on the next tick. In the buffered path, samples first pass through an internal sample FIFO. A controller then drains or replays that FIFO under one of three run modes, programmed through the mode input.

The buffered run modes are:
- **Counted:** a fixed number of samples goes out, then the block stops by itself.
- **Streaming:** samples go out with no limit while the host keeps writing, until a stop strobe arrives.
- **Replay:** a waveform already loaded in the FIFO loops without popping entries. Host writes are refused while it runs, so the FIFO contents stay put.

A start strobe with an illegal configuration raises an error flag and leaves the block idle. An empty FIFO at a streaming tick raises an underrun flag and halts generation.

Top module: `wave_seq`

## Requirements
- R1: After reset the following hold: `dac_stb_o`=0, `dac_data_o`=0, `busy_o`=0, `done_o`=0, `underrun_o`=0, `cfg_err_o`=0, `fifo_level_o`=0 and `wr_ready_o`=1.
- R2: With `buf_en_i`=0, an accepted write is held as a single pending sample, and `wr_ready_o` is 0 while it is pending. On the next tick the sample appears on `dac_data_o`, with `dac_stb_o` high in the cycle after the tick. A tick with nothing pending gives no strobe. `fifo_level_o` stays 0 throughout.
- R3: With `buf_en_i`=1, each accepted write raises `fifo_level_o` by one, and `wr_ready_o` is 0 when the FIFO holds DEPTH entries. Ticks produce no strobe until a start.
- R4: `run_mode_i`=0 (counted) with `count_i`=N outputs the first N FIFO samples in write order, one per tick. After the Nth sample `done_o`=1 and `busy_o`=0, and later ticks give no strobe.
- R5: `run_mode_i`=1 (streaming) outputs one FIFO sample per tick with no count limit until a stop. Host writes are accepted while it runs.
- R6: In counted or streaming mode, a tick with an empty FIFO gives no strobe, sets `underrun_o`=1 and moves to done (`done_o`=1, `busy_o`=0).
- R7: `run_mode_i`=2 (replay) with `count_i`=L outputs the first L loaded samples in order and repeats them cyclically. `fifo_level_o` does not change while it runs.
- R8: While replay runs, `wr_ready_o`=0 and a write with `wr_valid_i`=1 changes neither `fifo_level_o` nor the replayed sequence.
- R9: A start sets `cfg_err_o`=1 and leaves `busy_o`=0, with no strobe on later ticks, in any of these cases: replay with `count_i` of 0, above DEPTH or above `fifo_level_o`; counted mode with `count_i`=0; or `run_mode_i`=3. A later valid start clears `cfg_err_o`.
- R10: A stop strobe returns the block to idle from any state. It empties the FIFO (`fifo_level_o`=0) and clears `done_o`, `underrun_o` and `cfg_err_o`.
- R11: `dac_stb_o` is high for exactly one cycle per output sample, in the cycle right after the tick that released it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Host sample valid |
| wr_data_i | input | DATA_W | Host sample |
| wr_ready_o | output | 1 | Host sample accepted when high with valid |
| buf_en_i | input | 1 | 1 selects the FIFO path, 0 the direct path |
| run_mode_i | input | 2 | 0 counted, 1 streaming, 2 replay, 3 reserved |
| count_i | input | CNT_W | Sample count (counted) or waveform length (replay) |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| tick_i | input | 1 | Single-cycle update tick |
| dac_data_o | output | DATA_W | Sample to DAC |
| dac_stb_o | output | 1 | One-cycle strobe with each sample |
| busy_o | output | 1 | Generation running |
| done_o | output | 1 | Generation ended by count or underrun |
| underrun_o | output | 1 | FIFO empty at a streaming tick |
| cfg_err_o | output | 1 | Last start was rejected |
| fifo_level_o | output | $clog2(DEPTH+1) | FIFO occupancy |

## Verification
The direct path is tried with a set of words that includes all-zero, all-one and alternating bit patterns, which exposes stuck or swapped data bits.

A table of buffered runs crosses counted and streaming mode with loads shorter than, equal to and longer than the count. These separate a count that ends the run from an underrun that ends it, and check the output order against the write order.

Replay is run twice: once with a length below the FIFO occupancy, which shows it loops over the stated length rather than the whole FIFO, and once at full depth, which exercises the address wrap. Rejected starts are tried at each illegal length.

// File: rtl/wave_pkg.sv
package wave_pkg;
  typedef enum logic [1:0] {
    RM_COUNTED = 2'd0,
    RM_STREAM  = 2'd1,
    RM_REPLAY  = 2'd2,
    RM_RSVD    = 2'd3
  } run_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/wave_fifo.sv
module wave_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  input  logic              flush_i,
  input  logic              lock_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [AW-1:0]     head_o,
  output logic [LW-1:0]     level_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [LW-1:0]     level_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign rdata_o = mem_q[raddr_i];
  assign head_o  = rd_ptr_q;
  assign level_o = level_q;
  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  p_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_locked_no_push_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |-> !push_i);
endmodule

// File: rtl/wave_ctrl.sv
module wave_ctrl
  import wave_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             buf_en_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             push_i,
  input  logic [LW-1:0]    level_i,
  input  logic             empty_i,
  input  logic [AW-1:0]    head_i,
  output logic             emit_o,
  output logic             pop_o,
  output logic             flush_o,
  output logic             lock_o,
  output logic [AW-1:0]    raddr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             underrun_o,
  output logic             cfg_err_o
);
  seq_state_e       state_q;
  run_mode_e        mode_q, mode_in;
  logic [CNT_W-1:0] len_q, rem_q;
  logic [AW-1:0]    base_q, idx_q;
  logic             underrun_q, cfg_err_q;
  logic             running, replay_run, start_go, cfg_bad;
  logic [AW:0]      addr_sum;

  assign mode_in    = run_mode_e'(mode_i);
  assign running    = (state_q == ST_RUN);
  assign replay_run = running && (mode_q == RM_REPLAY);
  assign start_go   = start_i && buf_en_i && !running && !stop_i;

  always_comb begin
    unique case (mode_in)
      RM_COUNTED: cfg_bad = (count_i == '0);
      RM_STREAM:  cfg_bad = 1'b0;
      RM_REPLAY:  cfg_bad = (count_i == '0) || (count_i > CNT_W'(DEPTH))
                            || (count_i > CNT_W'(level_i));
      default:    cfg_bad = 1'b1;
    endcase
  end

  // replay address wraps modulo DEPTH
  assign addr_sum = {1'b0, base_q} + {1'b0, idx_q};
  always_comb begin
    if (addr_sum >= (AW+1)'(DEPTH)) raddr_o = AW'(addr_sum - (AW+1)'(DEPTH));
    else                            raddr_o = addr_sum[AW-1:0];
    if (!replay_run)                raddr_o = head_i;
  end

  assign emit_o  = running && tick_i && !stop_i && (mode_q == RM_REPLAY || !empty_i);
  assign pop_o   = emit_o && (mode_q != RM_REPLAY);
  assign flush_o = stop_i;
  assign lock_o  = replay_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= RM_COUNTED;
      len_q      <= '0;
      rem_q      <= '0;
      base_q     <= '0;
      idx_q      <= '0;
      underrun_q <= 1'b0;
      cfg_err_q  <= 1'b0;
    end else if (stop_i) begin
      state_q    <= ST_IDLE;
      underrun_q <= 1'b0;
      cfg_err_q  <= 1'b0;
    end else if (start_go) begin
      underrun_q <= 1'b0;
      if (cfg_bad) begin
        cfg_err_q <= 1'b1;
        state_q   <= ST_IDLE;
      end else begin
        cfg_err_q <= 1'b0;
        state_q   <= ST_RUN;
        mode_q    <= mode_in;
        len_q     <= count_i;
        rem_q     <= count_i;
        base_q    <= head_i;
        idx_q     <= '0;
      end
    end else if (running && tick_i) begin
      if (mode_q == RM_REPLAY) begin
        if (CNT_W'(idx_q) + 1'b1 == len_q) idx_q <= '0;
        else                               idx_q <= idx_q + 1'b1;
      end else if (empty_i) begin
        underrun_q <= 1'b1;
        state_q    <= ST_DONE;
      end else if (mode_q == RM_COUNTED) begin
        rem_q <= rem_q - 1'b1;
        if (rem_q == CNT_W'(1)) state_q <= ST_DONE;
      end
    end else if (push_i && state_q == ST_IDLE) begin
      state_q <= ST_LOAD;
    end
  end

  assign busy_o     = running;
  assign done_o     = (state_q == ST_DONE);
  assign underrun_o = underrun_q;
  assign cfg_err_o  = cfg_err_q;

  p_replay_static_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (replay_run && !stop_i) |=> $stable(level_i));
  p_stop_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (level_i == '0));
  p_done_not_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

// File: rtl/wave_seq.sv
module wave_seq
  import wave_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  input  logic              buf_en_i,
  input  logic [1:0]        run_mode_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] dac_data_o,
  output logic              dac_stb_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              underrun_o,
  output logic              cfg_err_o,
  output logic [LW-1:0]     fifo_level_o
);
  logic              push, pop, flush, lock, emit, full, empty;
  logic [AW-1:0]     raddr, head;
  logic [DATA_W-1:0] rdata, pend_q;
  logic              pend_vld_q, direct_out;

  assign wr_ready_o = buf_en_i ? (!full && !lock) : !pend_vld_q;
  assign push       = buf_en_i && wr_valid_i && wr_ready_o;
  assign direct_out = !buf_en_i && tick_i && pend_vld_q;

  wave_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (push),  .wdata_i (wr_data_i), .pop_i (pop), .flush_i (flush),
    .lock_i (lock),  .raddr_i (raddr),     .rdata_o (rdata),
    .head_o (head),  .level_o (fifo_level_o), .full_o (full), .empty_o (empty)
  );

  wave_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .buf_en_i, .start_i, .stop_i, .tick_i,
    .mode_i (run_mode_i), .count_i,
    .push_i (push), .level_i (fifo_level_o), .empty_i (empty), .head_i (head),
    .emit_o (emit), .pop_o (pop), .flush_o (flush), .lock_o (lock),
    .raddr_o (raddr), .busy_o, .done_o, .underrun_o, .cfg_err_o
  );

  // direct path: one-entry holding register, bypasses the FIFO
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q <= 1'b0;
      pend_q     <= '0;
    end else if (direct_out) begin
      pend_vld_q <= 1'b0;
    end else if (!buf_en_i && wr_valid_i && wr_ready_o) begin
      pend_vld_q <= 1'b1;
      pend_q     <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_data_o <= '0;
      dac_stb_o  <= 1'b0;
    end else begin
      dac_stb_o <= 1'b0;
      if (direct_out) begin
        dac_data_o <= pend_q;
        dac_stb_o  <= 1'b1;
      end else if (emit) begin
        dac_data_o <= rdata;
        dac_stb_o  <= 1'b1;
      end
    end
  end

  p_stb_after_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_stb_o |-> $past(tick_i));
  p_direct_fifo_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!buf_en_i && $past(!buf_en_i) && $past(fifo_level_o == '0)) |-> (fifo_level_o == '0));
endmodule

// File: tb/sim_wave_seq.sv
module sim_wave_seq;
  localparam int CLK_P = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int CW    = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, buf_en = 0, start = 0, stop = 0, tick = 0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] mode = '0;
  logic [CW-1:0] count = '0;
  logic wr_ready, dac_stb, busy, done, underrun, cfg_err;
  logic [DW-1:0] dac_data;
  logic [LW-1:0] level;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  wave_seq #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_ready_o(wr_ready), .buf_en_i(buf_en), .run_mode_i(mode), .count_i(count),
    .start_i(start), .stop_i(stop), .tick_i(tick), .dac_data_o(dac_data),
    .dac_stb_o(dac_stb), .busy_o(busy), .done_o(done), .underrun_o(underrun),
    .cfg_err_o(cfg_err), .fifo_level_o(level)
  );

  typedef struct packed {
    logic [1:0] md;
    logic [7:0] cnt, nload, nticks, nstb;
    logic       dn, ur;
  } vec_t;

  // buffered run table: mode, count, samples loaded, ticks, strobes, done, underrun
  localparam vec_t VT [6] = '{
    '{2'd0, 8'd3, 8'd5, 8'd5, 8'd3, 1'b1, 1'b0},
    '{2'd0, 8'd5, 8'd5, 8'd6, 8'd5, 1'b1, 1'b0},
    '{2'd0, 8'd4, 8'd2, 8'd4, 8'd2, 1'b1, 1'b1},
    '{2'd1, 8'd0, 8'd3, 8'd3, 8'd3, 1'b0, 1'b0},
    '{2'd1, 8'd0, 8'd2, 8'd4, 8'd2, 1'b1, 1'b1},
    '{2'd0, 8'd1, 8'd1, 8'd2, 8'd1, 1'b1, 1'b0}
  };
  localparam logic [DW-1:0] DVEC [6] = '{16'h0000, 16'hFFFF, 16'hAAAA, 16'h5555, 16'h0001, 16'h8000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic pulse_tick(output logic s, output logic [DW-1:0] d);
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0; s = dac_stb; d = dac_data;
  endtask

  task automatic do_start(input logic [1:0] m, input logic [CW-1:0] c);
    @(negedge clk); mode = m; count = c; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic s;
    logic [DW-1:0] d;
    int nstb;
    #(CLK_P * 3);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 stb", dac_stb, 0);
    check("R1 data", dac_data, 0);
    check("R1 flags", {busy, done, underrun, cfg_err}, 0);
    check("R1 level", level, 0);
    check("R1 ready", wr_ready, 1);

    // R2 direct path, table of data patterns
    for (int i = 0; i < 6; i++) begin
      wr(DVEC[i]);
      check("R2 ready low while pending", wr_ready, 0);
      check("R2 level stays 0", level, 0);
      pulse_tick(s, d);
      check("R2 stb", s, 1);
      check("R2 data", d, DVEC[i]);
      @(negedge clk);
      check("R11 stb one cycle", dac_stb, 0);
    end
    pulse_tick(s, d);
    check("R2 no pending no stb", s, 0);

    // buffered run table (R4 R5 R6)
    buf_en = 1;
    for (int k = 0; k < 6; k++) begin
      do_stop();
      for (int i = 0; i < int'(VT[k].nload); i++) wr(DW'(k * 16 + i));
      check("R3 level after load", level, VT[k].nload);
      do_start(VT[k].md, CW'(VT[k].cnt));
      nstb = 0;
      for (int t = 0; t < int'(VT[k].nticks); t++) begin
        pulse_tick(s, d);
        if (s) begin
          check("R4/R5 order", d, DW'(k * 16 + nstb));
          nstb++;
        end
      end
      check("R4 R5 R6 strobe count", nstb, VT[k].nstb);
      check("R4 R6 done", done, VT[k].dn);
      check("R6 underrun", underrun, VT[k].ur);
    end

    // R10 stop clears underrun/done
    do_stop();
    check("R10 stop clears", {done, underrun, busy, cfg_err}, 0);
    check("R10 level 0", level, 0);

    // R3 idle ticks, full flag
    for (int i = 0; i < DEPTH; i++) wr(DW'(16'h100 + i));
    check("R3 full ready", wr_ready, 0);
    check("R3 full level", level, DEPTH);
    pulse_tick(s, d);
    check("R3 idle tick no stb", s, 0);

    // R9 replay length above DEPTH
    do_start(2'd2, CW'(DEPTH + 1));
    check("R9 err", cfg_err, 1);
    check("R9 idle", busy, 0);
    pulse_tick(s, d);
    check("R9 no stb", s, 0);
    // R7 full-depth replay with wrap
    do_start(2'd2, CW'(DEPTH));
    check("R9 cleared by good start", cfg_err, 0);
    check("R7 busy", busy, 1);
    for (int t = 0; t <= DEPTH; t++) begin
      pulse_tick(s, d);
      check("R7 full replay", {s, d}, {1'b1, DW'(16'h100 + (t % DEPTH))});
    end
    check("R7 level static", level, DEPTH);

    // R7 R8 partial replay
    do_stop();
    for (int i = 0; i < 4; i++) wr(DW'(16'hA0 + i));
    do_start(2'd2, 3);
    check("R8 ready low", wr_ready, 0);
    wr(16'hDEAD);
    check("R8 level unchanged", level, 4);
    for (int t = 0; t < 7; t++) begin
      pulse_tick(s, d);
      check("R7 R8 replay seq", {s, d}, {1'b1, DW'(16'hA0 + (t % 3))});
    end
    check("R7 level", level, 4);
    do_stop();
    check("R10 stop from replay", {busy, level}, 0);

    // R9 other rejected starts
    wr(16'h1); wr(16'h2);
    do_start(2'd2, 3);
    check("R9 len above level", {cfg_err, busy}, 2'b10);
    do_start(2'd2, 0);
    check("R9 len zero", {cfg_err, busy}, 2'b10);
    do_start(2'd0, 0);
    check("R9 counted zero", {cfg_err, busy}, 2'b10);
    do_start(2'd3, 1);
    check("R9 reserved mode", {cfg_err, busy}, 2'b10);
    do_stop();
    check("R10 clears cfg_err", cfg_err, 0);

    // R5 writes during streaming
    wr(16'hB0);
    do_start(2'd1, 0);
    pulse_tick(s, d);
    check("R5 first", {s, d}, {1'b1, 16'hB0});
    check("R5 ready during run", wr_ready, 1);
    wr(16'hB1);
    pulse_tick(s, d);
    check("R5 written during run", {s, d}, {1'b1, 16'hB1});
    check("R5 still busy", busy, 1);

    // R10 stop mid counted run
    do_stop();
    for (int i = 0; i < 5; i++) wr(DW'(i));
    do_start(2'd0, 5);
    pulse_tick(s, d);
    pulse_tick(s, d);
    do_stop();
    check("R10 stop mid run", {busy, done, level}, 0);
    pulse_tick(s, d);
    check("R10 no stb after stop", s, 0);

    summary();
  end
endmodule